// File: doc/BRIEF.md
# Fixed-Latency Block Memory

This block stands in for the main memory behind a direct-mapped, write-through data cache. It takes one request at a time and keeps it for a fixed number of cycles. A read hands back a whole 128-bit line so that a cache refill needs only one access. A write stores a single 32-bit word, which matches a write-through store.

A requester places an address, write data and one or both strobes on the inputs during a cycle in which `ready` is high. The block captures all of them at that clock edge and pulls `ready` low for exactly `LATENCY` cycles. It raises `ready` again in the cycle after that. The returned line has no output register. It is formed combinationally from the storage and the captured address, so it is already valid during the last busy cycle. It then stays steady until the block accepts the next request. The storage is a small array of 256 lines, and any address outside that range wraps around onto it.

Top module: `blockmem_lat`

## Requirements
- R1: While reset is held and in the first cycle after it, `ready` is 1 and no access is in progress.
- R2: A request (`req_rd` or `req_wr` at 1) presented in a cycle with `ready` at 1 is captured at that clock edge. `ready` is then 0 for exactly `LATENCY` consecutive cycles (default 3) and returns to 1 in the cycle after.
- R3: A read returns the line selected by address bits [11:4]. Bits [31:12] are ignored, so addresses wrap over 256 lines. Bits [32k+31:32k] of `blk_rdata` carry the word at byte offset 4k of the line. The data is valid from the last busy cycle on and holds until the next accepted request.
- R4: A write stores `req_wdata` into word lane `req_addr[3:2]` of line `req_addr[11:4]`. The other three lanes keep their values, and later reads of that line return the stored word.
- R5: A request presented while `ready` is 0 is ignored. It changes no stored word and does not lengthen the busy period.
- R6: Address and write data are sampled only at the accepting edge. Changes to them during the busy period have no effect on the access.
- R7: A request with both strobes set writes the word and reads the same line. `blk_rdata` already contains the new word in the last busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_addr | input | 32 | Byte address of the request |
| req_wdata | input | 32 | Word to store on a write |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| blk_rdata | output | 128 | Line selected by the captured address, combinational |
| ready | output | 1 | High when idle and able to accept a request |

## Verification
A write commit and a read of the same line can fall in the same cycle. In the last busy cycle of a write, the word has not yet reached the storage, yet the line on `blk_rdata` must already include it. The bench provokes this with a request that sets both strobes. It also checks a write to a line whose other lanes were filled earlier. The line seen in the last busy cycle is compared lane by lane against a model that already holds the new word and the untouched neighbours. A follow-up read after the commit then confirms that the storage itself took the word.

// File: rtl/lbm_pkg.sv
package lbm_pkg;
  typedef struct packed {
    logic rd;
    logic wr;
  } lbm_op_t;
endpackage

// File: rtl/lbm_seq.sv
module lbm_seq
  import lbm_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LATENCY = 3,
  parameter int IDX_W   = 8,
  parameter int LANE_W  = 2,
  parameter int OFS_LSB = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_rd,
  input  logic              req_wr,
  output logic              ready,
  output logic [IDX_W-1:0]  cap_idx,
  output logic [LANE_W-1:0] cap_lane,
  output logic [DATA_W-1:0] cap_wdata,
  output logic              commit,
  output logic              pend_wr
);
  localparam int CNT_W   = $clog2(LATENCY + 1);
  localparam int IDX_LSB = OFS_LSB + LANE_W;
  localparam int IDX_MSB = IDX_LSB + IDX_W;

  logic [CNT_W-1:0] cnt_q;
  logic             rdy_q;
  lbm_op_t          op_q;
  logic             accept;
  logic             addr_unused;

  assign accept      = rdy_q & (req_rd | req_wr);
  assign addr_unused = ^{req_addr[ADDR_W-1:IDX_MSB], req_addr[OFS_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q     <= '0;
      rdy_q     <= 1'b1;
      op_q      <= '0;
      cap_idx   <= '0;
      cap_lane  <= '0;
      cap_wdata <= '0;
    end else if (accept) begin
      cnt_q     <= CNT_W'(LATENCY);
      rdy_q     <= 1'b0;
      op_q.rd   <= req_rd;
      op_q.wr   <= req_wr;
      cap_idx   <= req_addr[IDX_LSB +: IDX_W];
      cap_lane  <= req_addr[OFS_LSB +: LANE_W];
      cap_wdata <= req_wdata;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) rdy_q <= 1'b1;
    end
  end

  assign ready   = rdy_q;
  assign commit  = op_q.wr & (cnt_q == CNT_W'(1));
  assign pend_wr = op_q.wr & (cnt_q != '0);

  AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (rst)
    (ready && (req_rd || req_wr)) |=> !ready); // R2
  AST_READY_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == CNT_W'(1)) |=> ready); // R2
  AST_READY_TRACKS_COUNT: assert property (@(posedge clk) disable iff (rst)
    ready == (cnt_q == '0)); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CNT_W'(LATENCY)); // R2
  AST_CAPTURE_HELD: assert property (@(posedge clk) disable iff (rst)
    !ready |=> ($stable(cap_idx) && $stable(cap_lane))); // R5
  AST_WDATA_HELD: assert property (@(posedge clk) disable iff (rst)
    !ready |=> $stable(cap_wdata)); // R6
endmodule

// File: rtl/lbm_store.sv
module lbm_store #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int DEPTH  = 256,
  parameter int IDX_W  = 8,
  parameter int LANE_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [LANE_W-1:0]       lane,
  input  logic [DATA_W-1:0]       wdata,
  output logic [LANES*DATA_W-1:0] rd_line
);
  logic [LANES-1:0] lane_we;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DATA_W-1:0] arr [DEPTH];
    logic [DATA_W-1:0] rd_word;

    assign lane_we[g] = we & (lane == LANE_W'(g));

    always_ff @(posedge clk) begin
      if (lane_we[g]) arr[idx] <= wdata;
    end

    assign rd_word                    = arr[idx];
    assign rd_line[g*DATA_W +: DATA_W] = rd_word;

    AST_WRITE_VISIBLE: assert property (@(posedge clk) disable iff (rst)
      lane_we[g] |=> (rd_word == $past(wdata))); // R4
  end

  AST_ONE_LANE_WRITTEN: assert property (@(posedge clk) disable iff (rst)
    $onehot0(lane_we)); // R4
endmodule

// File: rtl/lbm_bypass.sv
module lbm_bypass #(
  parameter int DATA_W = 32,
  parameter int LANES  = 4,
  parameter int LANE_W = 2
) (
  input  logic [LANES*DATA_W-1:0] line_in,
  input  logic                    pend_wr,
  input  logic [LANE_W-1:0]       lane,
  input  logic [DATA_W-1:0]       wdata,
  output logic [LANES*DATA_W-1:0] line_out
);
  for (genvar g = 0; g < LANES; g++) begin : g_mux
    always_comb begin
      if (pend_wr && (lane == LANE_W'(g))) line_out[g*DATA_W +: DATA_W] = wdata;
      else line_out[g*DATA_W +: DATA_W] = line_in[g*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/blockmem_lat.sv
module blockmem_lat #(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int LANES   = 4,
  parameter int DEPTH   = 256,
  parameter int LATENCY = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic [DATA_W-1:0]       req_wdata,
  input  logic                    req_rd,
  input  logic                    req_wr,
  output logic [LANES*DATA_W-1:0] blk_rdata,
  output logic                    ready
);
  localparam int IDX_W   = $clog2(DEPTH);
  localparam int LANE_W  = $clog2(LANES);
  localparam int OFS_LSB = $clog2(DATA_W / 8);

  logic [IDX_W-1:0]        cap_idx;
  logic [LANE_W-1:0]       cap_lane;
  logic [DATA_W-1:0]       cap_wdata;
  logic                    commit;
  logic                    pend_wr;
  logic [LANES*DATA_W-1:0] store_line;

  lbm_seq #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LATENCY(LATENCY),
    .IDX_W(IDX_W), .LANE_W(LANE_W), .OFS_LSB(OFS_LSB)
  ) u_seq (
    .clk(clk), .rst(rst),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rd(req_rd), .req_wr(req_wr),
    .ready(ready), .cap_idx(cap_idx), .cap_lane(cap_lane),
    .cap_wdata(cap_wdata), .commit(commit), .pend_wr(pend_wr)
  );

  lbm_store #(
    .DATA_W(DATA_W), .LANES(LANES), .DEPTH(DEPTH),
    .IDX_W(IDX_W), .LANE_W(LANE_W)
  ) u_store (
    .clk(clk), .rst(rst), .we(commit),
    .idx(cap_idx), .lane(cap_lane), .wdata(cap_wdata),
    .rd_line(store_line)
  );

  lbm_bypass #(
    .DATA_W(DATA_W), .LANES(LANES), .LANE_W(LANE_W)
  ) u_byp (
    .line_in(store_line), .pend_wr(pend_wr),
    .lane(cap_lane), .wdata(cap_wdata),
    .line_out(blk_rdata)
  );

  AST_LINE_STABLE_IDLE: assert property (@(posedge clk) disable iff (rst)
    ($past(ready) && ready && !$past(req_rd) && !$past(req_wr)) |-> $stable(blk_rdata)); // R3
endmodule

// File: tb/sim_blockmem_lat.sv
`timescale 1ns/1ps
module sim_blockmem_lat;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [31:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         req_rd = 1'b0;
  logic         req_wr = 1'b0;
  logic [127:0] blk_rdata;
  logic         ready;

  typedef struct {
    logic [127:0] exp;
    logic [3:0]   msk;
    string        tag;
  } item_t;

  item_t       sbq[$];
  logic [31:0] mdl [256][4];
  bit          known [256][4];
  int          checks = 0;
  int          errors = 0;
  int          run = 0;
  bit          done = 1'b0;

  blockmem_lat #(.LATENCY(LAT)) u0 (
    .clk(clk), .rst(rst), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_rd(req_rd), .req_wr(req_wr), .blk_rdata(blk_rdata), .ready(ready)
  );

  always #10 clk = ~clk;

  task automatic issue(input bit rd, input bit wr, input logic [31:0] a,
                       input logic [31:0] d, input bit stray, input string tag);
    item_t it;
    int    idx;
    int    ln;
    @(negedge clk);
    while (!ready) @(negedge clk);
    req_addr = a; req_wdata = d; req_rd = rd; req_wr = wr;
    idx = int'(a[11:4]); ln = int'(a[3:2]);
    if (wr) begin mdl[idx][ln] = d; known[idx][ln] = 1'b1; end
    for (int k = 0; k < 4; k++) begin
      it.exp[32*k +: 32] = known[idx][k] ? mdl[idx][k] : 32'h0;
      it.msk[k] = known[idx][k];
    end
    it.tag = tag;
    sbq.push_back(it);
    @(negedge clk);
    req_wdata = ~d;             // R6: late change must not matter
    req_addr  = a ^ 32'h0000_0040;
    if (stray) begin            // R5: request while busy
      req_rd = 1'b0; req_wr = 1'b1;
      req_addr = 32'h0000_0090; req_wdata = 32'hDEAD_BEEF;
    end else begin
      req_rd = 1'b0; req_wr = 1'b0;
    end
    while (!ready) @(negedge clk);
    req_rd = 1'b0; req_wr = 1'b0;
  endtask

  // monitor: pop the expected line in the last busy cycle, measure busy span
  always @(negedge clk) begin
    if (!rst) begin
      if (!ready) begin
        run = run + 1;
        if (run == LAT) begin
          checks++;
          if (sbq.size() == 0) begin
            errors++;
            $display("FAIL R3 unexpected access actual=%h expected=<none>", blk_rdata);
          end else begin
            item_t it;
            logic [127:0] m;
            it = sbq.pop_front();
            for (int k = 0; k < 4; k++) m[32*k +: 32] = {32{it.msk[k]}};
            if ((blk_rdata & m) !== (it.exp & m)) begin
              errors++;
              $display("FAIL %s line actual=%h expected=%h mask=%b",
                       it.tag, blk_rdata & m, it.exp & m, it.msk);
            end
          end
        end
      end else if (run != 0) begin
        checks++;
        if (run != LAT) begin
          errors++;
          $display("FAIL R2 busy span actual=%0d expected=%0d", run, LAT);
        end
        run = 0;
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=expired expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++)
      for (int k = 0; k < 4; k++) known[i][k] = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (ready !== 1'b1) begin
      errors++; $display("FAIL R1 ready in reset actual=%b expected=1", ready);
    end
    rst = 1'b0;
    @(negedge clk);
    checks++;
    if (ready !== 1'b1) begin
      errors++; $display("FAIL R1 ready after reset actual=%b expected=1", ready);
    end

    for (int k = 0; k < 4; k++) issue(0, 1, 32'h50 + 32'(4*k), 32'hA0A0_0000 + 32'(k), 0, "R4");
    for (int k = 0; k < 4; k++) issue(0, 1, 32'h90 + 32'(4*k), 32'hB0B0_0000 + 32'(k), 0, "R4");
    issue(1, 0, 32'h0000_0050, 32'h0, 0, "R3");
    issue(1, 0, 32'hABCD_E05C, 32'h0, 0, "R3");   // aliases line 5
    issue(0, 1, 32'h0000_0058, 32'h1234_5678, 1, "R5");
    issue(1, 0, 32'h0000_0090, 32'h0, 0, "R5");   // stray write must not land
    issue(1, 0, 32'h0000_0050, 32'h0, 0, "R6");   // lane 2 holds sampled data
    issue(1, 1, 32'h0000_0094, 32'h5A5A_0001, 0, "R7");
    issue(1, 0, 32'h0000_0090, 32'h0, 0, "R4");
    for (int k = 0; k < 4; k++) issue(0, 1, 32'hFF0 + 32'(4*k), 32'hC0C0_0000 + 32'(k), 0, "R4");
    issue(1, 0, 32'h0000_0FFC, 32'h0, 0, "R3");
    issue(0, 1, 32'h0000_1000, 32'hD00D_0000, 0, "R4");
    issue(1, 0, 32'h0000_0000, 32'h0, 0, "R3");   // wrap onto line 0
    for (int i = 16; i < 24; i++) issue(0, 1, 32'(i) << 4 | 32'(4*(i%4)), 32'(i * 17), 0, "R4");
    for (int i = 16; i < 24; i++) issue(1, 0, 32'(i) << 4, 32'h0, 0, "R3");
    repeat (LAT + 3) @(negedge clk);
    checks++;
    if (sbq.size() != 0) begin
      errors++; $display("FAIL R2 pending items actual=%0d expected=0", sbq.size());
    end
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule